// File: doc/BRIEF.md
# Masked SIMD Lane Array

The block is a grid of eight identical processing lanes, two rows by four columns, that carry out one instruction per clock issued by an outside controller. Each lane holds a 64-bit accumulator, a private word memory and an active flag. Element i of a data array sits in lane i's memory, so a single broadcast instruction works on a whole vector at once. Lanes whose active flag is clear sit out every data instruction. This lets the controller run data-dependent code without branching: a compare instruction rewrites the flags, and the lanes that fail the test do nothing until they are switched back on.

The arithmetic path is packed. One add or subtract handles a single 64-bit word, two independent 32-bit halves or eight independent bytes, depending on a format field. A common scalar input carries an immediate value to every lane. A shift instruction copies each lane's accumulator from one of its four grid neighbours, and wraps at the edges. A registered read-back path returns one lane's memory word or accumulator to the controller.

Top module: `simd_lane_array`

## Requirements
- R1: After synchronous reset every accumulator is 0 and all eight `lane_act` bits are 1.
- R2: A lane with a clear active flag leaves its accumulator and its memory unchanged for opcodes 1 to 11. This covers loads, store, arithmetic, logic and shift.
- R3: Opcode 5 (acc+mem) and opcodes 6 (acc-mem) and 7 (acc+scalar) use `fmt`: 0 gives one 64-bit lane, 1 gives two 32-bit halves, 2 gives eight bytes, and 3 behaves as 0. No carry or borrow crosses a sub-word boundary.
- R4: Opcode 3 loads `scalar` into every active accumulator. Opcode 4 loads the lane's index (row*4+col, lanes 0-3 in row 0).
- R5: Opcode 11 copies into each active lane the pre-shift accumulator of one neighbour, chosen by `dir`. 0 takes row-1, 1 takes col+1, 2 takes row+1 and 3 takes col-1. All of these wrap modulo the grid size.
- R6: Opcode 12 sets the active flag of every lane, including disabled lanes, to (acc < scalar) as an unsigned compare.
- R7: Opcode 13 sets every active flag to 1.
- R8: These opcodes use the lane's own memory word at `addr`. Opcode 1 loads it, opcode 2 stores the accumulator there, and opcodes 8/9/10 form acc AND/OR/XOR with it. Opcode 0 does nothing.
- R9: `rd_data` shows the value selected by `rd_lane`/`rd_addr`/`rd_acc` one clock edge after it is selected. `rd_acc`=1 selects the accumulator and 0 selects the memory word.
- R10: Accumulators, memories and `lane_act` take an instruction's result at the clock edge where that instruction is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Broadcast opcode |
| fmt | input | 2 | Packed format for add/subtract |
| dir | input | 2 | Shift source direction |
| addr | input | 6 | Broadcast memory address |
| scalar | input | 64 | Broadcast scalar |
| rd_lane | input | 3 | Lane selected for read-back |
| rd_addr | input | 6 | Memory word selected for read-back |
| rd_acc | input | 1 | Read back accumulator instead of memory |
| rd_data | output | 64 | Read-back word |
| lane_act | output | 8 | Active flag of each lane |

## Verification
An instruction changes the accumulators, memories and `lane_act` at the single edge on which it is sampled. The bench therefore drives each instruction at a falling edge and checks `lane_act` at the next falling edge. Read-back adds one more register, so each accumulator or memory word is sampled one full cycle after its selection is driven. A directed check also confirms that `rd_data` still holds the old value before that edge. Expected values come from a lane-by-lane model in the bench that takes a snapshot of all lanes before each step, so shifts and masked lanes are predicted from the pre-instruction state.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int WORD_W = 64;
    localparam int BYTES  = WORD_W / 8;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,  OP_LDM  = 4'd1,  OP_STM = 4'd2,  OP_LDS = 4'd3,
        OP_LDI  = 4'd4,  OP_ADDM = 4'd5,  OP_SUBM = 4'd6, OP_ADDS = 4'd7,
        OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR = 4'd10, OP_SHF = 4'd11,
        OP_MLT  = 4'd12, OP_MALL = 4'd13
    } op_e;

    typedef enum logic [1:0] {FMT_D = 2'd0, FMT_W = 2'd1, FMT_B = 2'd2} fmt_e;
    typedef enum logic [1:0] {DIR_N = 2'd0, DIR_E = 2'd1, DIR_S = 2'd2, DIR_W = 2'd3} dir_e;

    // Byte-sliced add/subtract; the carry chain restarts at each sub-word start.
    function automatic logic [WORD_W-1:0] packed_addsub(
        input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
        input logic sub, input logic [1:0] f);
        logic [WORD_W-1:0] r;
        logic [WORD_W-1:0] bb;
        logic [8:0] s;
        logic c;
        bb = sub ? ~b : b;
        c  = sub;
        r  = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (i != 0 && (f == FMT_B || (f == FMT_W && i == BYTES/2)))
                c = sub;
            s = {1'b0, a[8*i +: 8]} + {1'b0, bb[8*i +: 8]} + {8'd0, c};
            r[8*i +: 8] = s[7:0];
            c = s[8];
        end
        return r;
    endfunction

    function automatic logic writes_acc(input op_e o);
        return (o inside {OP_LDM, OP_LDS, OP_LDI, OP_ADDM, OP_SUBM, OP_ADDS,
                          OP_AND, OP_OR, OP_XOR, OP_SHF});
    endfunction
endpackage

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int LANE_ID = 0
) (
    input  op_e               op,
    input  logic [1:0]        fmt,
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] scalar,
    input  logic [WORD_W-1:0] nbr_word,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        unique case (op)
            OP_LDM:  result = mem_word;
            OP_LDS:  result = scalar;
            OP_LDI:  result = WORD_W'(LANE_ID);
            OP_ADDM: result = packed_addsub(acc, mem_word, 1'b0, fmt);
            OP_SUBM: result = packed_addsub(acc, mem_word, 1'b1, fmt);
            OP_ADDS: result = packed_addsub(acc, scalar, 1'b0, fmt);
            OP_AND:  result = acc & mem_word;
            OP_OR:   result = acc | mem_word;
            OP_XOR:  result = acc ^ mem_word;
            OP_SHF:  result = nbr_word;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int LANE_ID = 0,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [1:0]        fmt,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] scalar,
    input  logic [WORD_W-1:0] nbr_in,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] acc_o,
    output logic [WORD_W-1:0] rd_word,
    output logic              act_o
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] alu_res;
    logic              act_q;

    simd_alu #(.LANE_ID(LANE_ID)) u_alu (
        .op(op), .fmt(fmt), .acc(acc_q), .mem_word(mem[addr]),
        .scalar(scalar), .nbr_word(nbr_in), .result(alu_res)
    );

    always_ff @(posedge clk) begin
        if (act_q && op == OP_STM)
            mem[addr] <= acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (act_q && writes_acc(op))
            acc_q <= alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= 1'b1;
        else if (op == OP_MALL)
            act_q <= 1'b1;
        else if (op == OP_MLT)
            act_q <= (acc_q < scalar);
    end

    assign acc_o   = acc_q;
    assign act_o   = act_q;
    assign rd_word = mem[rd_addr];

    a_r2_masked_hold: assert property (@(posedge clk) disable iff (rst)
        (!act_q && writes_acc(op)) |=> (acc_q == $past(acc_q)));
    a_r4_scalar_load: assert property (@(posedge clk) disable iff (rst)
        (act_q && op == OP_LDS) |=> (acc_q == $past(scalar)));
    a_r6_mask_compare: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MLT) |=> (act_q == ($past(acc_q) < $past(scalar))));
    a_r7_reenable: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MALL) |=> act_q);
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int ROWS  = 2,
    parameter int COLS  = 4,
    parameter int DEPTH = 64,
    localparam int LANES = ROWS * COLS,
    localparam int LW    = $clog2(LANES),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [1:0]        fmt,
    input  logic [1:0]        dir,
    input  logic [AW-1:0]     addr,
    input  logic [63:0]       scalar,
    input  logic [LW-1:0]     rd_lane,
    input  logic [AW-1:0]     rd_addr,
    input  logic              rd_acc,
    output logic [63:0]       rd_data,
    output logic [LANES-1:0]  lane_act
);
    op_e               op_c;
    logic [WORD_W-1:0] acc_w  [LANES];
    logic [WORD_W-1:0] rdw_w  [LANES];
    logic [WORD_W-1:0] nbr_w  [LANES];

    assign op_c = op_e'(op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int R  = g / COLS;
        localparam int C  = g % COLS;
        localparam int NN = ((R + ROWS - 1) % ROWS) * COLS + C;
        localparam int NE = R * COLS + (C + 1) % COLS;
        localparam int NS = ((R + 1) % ROWS) * COLS + C;
        localparam int NW = R * COLS + (C + COLS - 1) % COLS;

        always_comb begin
            unique case (dir_e'(dir))
                DIR_N:   nbr_w[g] = acc_w[NN];
                DIR_E:   nbr_w[g] = acc_w[NE];
                DIR_S:   nbr_w[g] = acc_w[NS];
                default: nbr_w[g] = acc_w[NW];
            endcase
        end

        simd_lane #(.LANE_ID(g), .DEPTH(DEPTH)) u_lane (
            .clk(clk), .rst(rst), .op(op_c), .fmt(fmt), .addr(addr),
            .scalar(scalar), .nbr_in(nbr_w[g]), .rd_addr(rd_addr),
            .acc_o(acc_w[g]), .rd_word(rdw_w[g]), .act_o(lane_act[g])
        );

        a_r5_shift_copy: assert property (@(posedge clk) disable iff (rst)
            (op_c == OP_SHF && lane_act[g]) |=> (acc_w[g] == $past(nbr_w[g])));
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_acc ? acc_w[rd_lane] : rdw_w[rd_lane];
    end

    a_r9_read_acc: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && $past(rd_acc) && $stable(rd_lane) && $past(op_c) == OP_NOP && op_c == OP_NOP)
        |=> (rd_data == $past(acc_w[rd_lane])));
endmodule

// File: tb/sim_simd_lane_array.sv
module sim_simd_lane_array;
    import simd_pkg::*;
    localparam int LANES = 8;
    localparam int DEPTH = 64;
    localparam int NADR  = 4;

    typedef struct packed {
        op_e         op;
        logic [1:0]  fmt;
        logic [1:0]  dir;
        logic [5:0]  addr;
        logic [63:0] sc;
    } vec_t;

    localparam int NVEC = 34;
    localparam vec_t VEC [NVEC] = '{
        '{OP_LDI,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_STM,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_LDS,  2'd0, 2'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{OP_ADDM, 2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_STM,  2'd0, 2'd0, 6'd1, 64'h0},
        '{OP_LDS,  2'd0, 2'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF},
        '{OP_ADDM, 2'd1, 2'd0, 6'd0, 64'h0},
        '{OP_STM,  2'd0, 2'd0, 6'd2, 64'h0},
        '{OP_LDS,  2'd0, 2'd0, 6'd0, 64'h01FF_7F80_00FF_FE01},
        '{OP_ADDM, 2'd2, 2'd0, 6'd0, 64'h0},
        '{OP_SUBM, 2'd2, 2'd0, 6'd1, 64'h0},
        '{OP_STM,  2'd0, 2'd0, 6'd3, 64'h0},
        '{OP_LDM,  2'd0, 2'd0, 6'd2, 64'h0},
        '{OP_SUBM, 2'd1, 2'd0, 6'd0, 64'h0},
        '{OP_XOR,  2'd0, 2'd0, 6'd1, 64'h0},
        '{OP_OR,   2'd0, 2'd0, 6'd3, 64'h0},
        '{OP_AND,  2'd0, 2'd0, 6'd2, 64'h0},
        '{OP_SUBM, 2'd0, 2'd0, 6'd1, 64'h0},
        '{OP_LDI,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_MLT,  2'd0, 2'd0, 6'd0, 64'd5},
        '{OP_ADDS, 2'd0, 2'd0, 6'd0, 64'h100},
        '{OP_SHF,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_SHF,  2'd0, 2'd1, 6'd0, 64'h0},
        '{OP_STM,  2'd0, 2'd0, 6'd1, 64'h0},
        '{OP_LDM,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_MALL, 2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_SHF,  2'd0, 2'd2, 6'd0, 64'h0},
        '{OP_SHF,  2'd0, 2'd3, 6'd0, 64'h0},
        '{OP_ADDS, 2'd2, 2'd0, 6'd0, 64'hF0F0_F0F0_F0F0_F0F0},
        '{OP_MLT,  2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_ADDM, 2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_MALL, 2'd0, 2'd0, 6'd0, 64'h0},
        '{OP_ADDS, 2'd3, 2'd0, 6'd0, 64'hFFFF_FFFF_0000_0001},
        '{OP_NOP,  2'd0, 2'd0, 6'd0, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op = 4'd0;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  dir = 2'd0;
    logic [5:0]  addr = 6'd0;
    logic [63:0] scalar = 64'd0;
    logic [2:0]  rd_lane = 3'd0;
    logic [5:0]  rd_addr = 6'd0;
    logic        rd_acc = 1'b0;
    logic [63:0] rd_data;
    logic [7:0]  lane_act;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m_acc [LANES];
    logic [63:0] m_mem [LANES][NADR];
    logic        m_wr  [LANES][NADR];
    logic [7:0]  m_act;

    always #5 clk = ~clk;

    simd_lane_array u0 (
        .clk(clk), .rst(rst), .op(op), .fmt(fmt), .dir(dir), .addr(addr),
        .scalar(scalar), .rd_lane(rd_lane), .rd_addr(rd_addr), .rd_acc(rd_acc),
        .rd_data(rd_data), .lane_act(lane_act)
    );

    function automatic logic [63:0] m_as(logic [63:0] a, logic [63:0] b, logic sub, logic [1:0] f);
        logic [63:0] r;
        if (f == 2'd1) begin
            r[31:0]  = sub ? a[31:0]  - b[31:0]  : a[31:0]  + b[31:0];
            r[63:32] = sub ? a[63:32] - b[63:32] : a[63:32] + b[63:32];
        end else if (f == 2'd2) begin
            for (int k = 0; k < 8; k++)
                r[8*k +: 8] = sub ? a[8*k +: 8] - b[8*k +: 8] : a[8*k +: 8] + b[8*k +: 8];
        end else begin
            r = sub ? a - b : a + b;
        end
        return r;
    endfunction

    function automatic int src_lane(int l, logic [1:0] d);
        int r = l / 4;
        int c = l % 4;
        case (d)
            2'd0: return ((r + 1) % 2) * 4 + c;
            2'd1: return r * 4 + (c + 1) % 4;
            2'd2: return ((r + 1) % 2) * 4 + c;
            default: return r * 4 + (c + 3) % 4;
        endcase
    endfunction

    function automatic string tag_of(op_e o);
        case (o)
            OP_ADDM, OP_SUBM, OP_ADDS: return "R3";
            OP_LDS, OP_LDI:            return "R4";
            OP_SHF:                    return "R5";
            OP_MLT:                    return "R6";
            OP_MALL:                   return "R7";
            default:                   return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act_v, logic [63:0] exp_v, string what);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic readback(int lane, logic sel, int a, output logic [63:0] v);
        @(negedge clk);
        rd_lane = 3'(lane);
        rd_acc  = sel;
        rd_addr = 6'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic model_step(vec_t v);
        logic [63:0] old_acc [LANES];
        logic [7:0]  old_act;
        old_act = m_act;
        for (int l = 0; l < LANES; l++) old_acc[l] = m_acc[l];
        for (int l = 0; l < LANES; l++) begin
            if (v.op == OP_MLT) m_act[l] = (old_acc[l] < v.sc);
            else if (v.op == OP_MALL) m_act[l] = 1'b1;
            else if (old_act[l]) begin
                case (v.op)
                    OP_LDM:  m_acc[l] = m_mem[l][v.addr];
                    OP_STM:  begin m_mem[l][v.addr] = old_acc[l]; m_wr[l][v.addr] = 1'b1; end
                    OP_LDS:  m_acc[l] = v.sc;
                    OP_LDI:  m_acc[l] = 64'(l);
                    OP_ADDM: m_acc[l] = m_as(old_acc[l], m_mem[l][v.addr], 1'b0, v.fmt);
                    OP_SUBM: m_acc[l] = m_as(old_acc[l], m_mem[l][v.addr], 1'b1, v.fmt);
                    OP_ADDS: m_acc[l] = m_as(old_acc[l], v.sc, 1'b0, v.fmt);
                    OP_AND:  m_acc[l] = old_acc[l] & m_mem[l][v.addr];
                    OP_OR:   m_acc[l] = old_acc[l] | m_mem[l][v.addr];
                    OP_XOR:  m_acc[l] = old_acc[l] ^ m_mem[l][v.addr];
                    OP_SHF:  m_acc[l] = old_acc[src_lane(l, v.dir)];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic run_vec(vec_t v);
        logic [7:0]  act_before;
        logic [63:0] got;
        string       t;
        act_before = m_act;
        @(negedge clk);
        op = v.op; fmt = v.fmt; dir = v.dir; addr = v.addr; scalar = v.sc;
        model_step(v);
        @(negedge clk);
        op = 4'd0;
        // R10: mask visible right after the issuing edge
        check((v.op == OP_MLT) ? "R6" : (v.op == OP_MALL) ? "R7" : "R10",
              64'(lane_act), 64'(m_act), "lane_act");
        for (int l = 0; l < LANES; l++) begin
            t = act_before[l] ? tag_of(v.op) : "R2";
            readback(l, 1'b1, 0, got);
            check(t, got, m_acc[l], $sformatf("acc lane %0d op %0d", l, v.op));
            for (int a = 0; a < NADR; a++) begin
                if (m_wr[l][a]) begin
                    readback(l, 1'b0, a, got);
                    check(t, got, m_mem[l][a], $sformatf("mem lane %0d addr %0d", l, a));
                end
            end
        end
    endtask

    initial begin
        logic [63:0] got;
        for (int l = 0; l < LANES; l++) begin
            m_acc[l] = '0;
            for (int a = 0; a < NADR; a++) begin m_mem[l][a] = '0; m_wr[l][a] = 1'b0; end
        end
        m_act = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", 64'(lane_act), 64'hFF, "reset lane_act");
        for (int l = 0; l < LANES; l++) begin
            readback(l, 1'b1, 0, got);
            check("R1", got, 64'h0, $sformatf("reset acc lane %0d", l));
        end

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R9: rd_data holds the previous selection until the next edge
        readback(6, 1'b1, 0, got);
        @(negedge clk);
        rd_lane = 3'd1; rd_acc = 1'b0; rd_addr = 6'd2;
        #1;
        check("R9", rd_data, m_acc[6], "rd_data before edge");
        @(negedge clk);
        check("R9", rd_data, m_mem[1][2], "rd_data after edge");

        // R3 corner: byte carry stop with all-ones plus one
        run_vec('{OP_LDS, 2'd0, 2'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF});
        run_vec('{OP_ADDS, 2'd2, 2'd0, 6'd0, 64'h0101_0101_0101_0101});
        check("R3", m_acc[0], 64'h0, "byte wrap model");

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int l = 0; l < LANES; l++) m_acc[l] = '0;
        m_act = 8'hFF;
        check("R1", 64'(lane_act), 64'hFF, "mid-run reset lane_act");
        readback(3, 1'b1, 0, got);
        check("R1", got, 64'h0, "mid-run reset acc lane 3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule